// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the part of a small 16-bit CPU that takes interrupts and returns from them. The core signals each instruction boundary with a one-cycle completion strobe. If the global interrupt enable in the status word is set and any request flag is pending at that boundary, the sequencer stalls the core. It saves the program counter and then the status word on a downward-growing stack in memory, picks the winning request, and clears that request's flag when the request has a single source. It then zeroes the status word and loads the program counter from the winner's vector slot.

A return command given at an instruction boundary runs the reverse walk. The status word is read back first, the program counter second, and the stack pointer moves up by two words. The architectural registers stay in the core. The sequencer only issues load strobes with new values, and it drives one word-wide memory port whose read data arrives one cycle after the request.

Top module: `irq_seq`

## Requirements
- R1: Entry starts only in an idle cycle in which `insn_done` is 1, bit 3 (global enable) of `sr_cur` is 1 and `irq_pend` is non-zero. In any other idle cycle the block issues no memory request and `busy` stays low.
- R2: The cycle after acceptance writes the program counter to the word-aligned stack pointer minus 2. The next cycle writes the status word to the aligned pointer minus 4 and loads the stack pointer with the aligned pointer minus 4. Bit 0 of `sp_cur` is ignored.
- R3: The winner is the highest-index bit set in `irq_pend` during the third busy cycle of entry. This includes requests raised after acceptance, and any bit seen at acceptance stays eligible.
- R4: For the winner only, `irq_clr` pulses for one cycle, and only when the winner's bit in `SINGLE_SRC_MASK` is 1. The default mask has bit 7 at 0, so request 7 is multi-source and its flag is left set.
- R5: During entry the status word is loaded with zero. This clears the global enable, so no further entry is accepted until the status word changes.
- R6: The program counter is loaded with the word read from `VEC_TOP - 2*id`. Read data is valid in the cycle after the read request. Entry keeps `busy` high for exactly 5 cycles.
- R7: A return starts in an idle cycle with `insn_done` and `reti_req` both 1. It takes precedence over a pending interrupt at that boundary. It reads the status word from the aligned pointer and the program counter from the aligned pointer plus 2, loads the stack pointer with the aligned pointer plus 4, writes nothing, and keeps `busy` high for exactly 3 cycles.
- R8: While `busy` is high, `insn_done` and `reti_req` have no effect on the sequence.
- R9: After reset, `busy`, `mem_req`, all load strobes and `irq_clr` are low until an acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_done | input | 1 | Current instruction completes this cycle |
| reti_req | input | 1 | The completing instruction is a return-from-interrupt |
| irq_pend | input | NUM_SRC | Pending request flags |
| irq_clr | output | NUM_SRC | One-cycle clear pulse for a single-source winner |
| pc_cur | input | 16 | Current program counter |
| sr_cur | input | 16 | Current status word |
| sp_cur | input | 16 | Current stack pointer |
| pc_load | output | 1 | Load the program counter |
| pc_next | output | 16 | New program counter |
| sr_load | output | 1 | Load the status word |
| sr_next | output | 16 | New status word |
| sp_load | output | 1 | Load the stack pointer |
| sp_next | output | 16 | New stack pointer |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Byte address of the access |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, one cycle after a read request |
| busy | output | 1 | Sequence in progress, core stalled |

## Verification
A wrong state register or a misordered transition shows up within one cycle as a memory access at the wrong address, or as a busy window of the wrong length. The bench records every memory transaction and counts busy cycles per sequence. A wrong saved value or a wrong pointer offset does not show up at entry. It shows up at the following return, when the restored program counter, status word or stack pointer differs from what was pushed. A wrong winner or a wrong clear pulse is seen as soon as entry completes: the loaded vector and the remaining flag pattern differ from the expected ones.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    localparam int WORD_W     = 16;
    localparam int WORD_BYTES = 2;
    localparam int GIE_BIT    = 3;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PUSH_PC,
        ST_PUSH_SR,
        ST_PICK,
        ST_VEC_RD,
        ST_VEC_LD,
        ST_POP_SR_RD,
        ST_POP_SR_LD,
        ST_POP_PC_LD
    } seq_state_e;

    typedef enum logic [1:0] {
        MEM_IDLE,
        MEM_WRITE,
        MEM_READ
    } mem_op_e;

    typedef struct packed {
        mem_op_e op;
        word_t   addr;
        word_t   wdata;
    } mem_cmd_t;

    typedef struct packed {
        logic  pc_ld;
        word_t pc_val;
        logic  sr_ld;
        word_t sr_val;
        logic  sp_ld;
        word_t sp_val;
    } reg_upd_t;

    function automatic word_t word_align(input word_t a);
        word_t r;
        r    = a;
        r[0] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/irq_prio.sv
module irq_prio #(
    parameter int NUM_SRC = 8,
    parameter int ID_W    = 3
) (
    input  logic [NUM_SRC-1:0] req,
    output logic               found,
    output logic [ID_W-1:0]    id
);

    // Scan upward: the last set bit seen is the highest index.
    always_comb begin
        found = 1'b0;
        id    = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req[i]) begin
                found = 1'b1;
                id    = ID_W'(i);
            end
        end
    end

    always_comb begin
        if (found) begin
            assert_winner_highest_R3: assert (req[id] && ((req >> id) == NUM_SRC'(1)));
        end
    end

endmodule

// File: rtl/irq_stack_agu.sv
module irq_stack_agu
    import irq_seq_pkg::*;
#(
    parameter int    ID_W    = 3,
    parameter word_t VEC_TOP = 16'hFFFE
) (
    input  word_t           sp_base,
    input  logic [ID_W-1:0] vec_id,
    output word_t           a_push_pc,
    output word_t           a_push_sr,
    output word_t           a_pop_sr,
    output word_t           a_pop_pc,
    output word_t           a_vec,
    output word_t           sp_pushed,
    output word_t           sp_popped
);

    localparam word_t STEP = word_t'(WORD_BYTES);

    assign a_push_pc = sp_base - STEP;
    assign a_push_sr = sp_base - (STEP << 1);
    assign sp_pushed = sp_base - (STEP << 1);
    assign a_pop_sr  = sp_base;
    assign a_pop_pc  = sp_base + STEP;
    assign sp_popped = sp_base + (STEP << 1);
    assign a_vec     = VEC_TOP - (word_t'(vec_id) * STEP);

endmodule

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
    import irq_seq_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int ID_W    = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               insn_done,
    input  logic               reti_req,
    input  logic [NUM_SRC-1:0] irq_pend,
    input  word_t              pc_cur,
    input  word_t              sr_cur,
    input  word_t              sp_cur,
    input  word_t              mem_rdata,
    input  logic               win_found,
    input  logic [ID_W-1:0]    win_id,
    input  word_t              a_push_pc,
    input  word_t              a_push_sr,
    input  word_t              a_pop_sr,
    input  word_t              a_pop_pc,
    input  word_t              a_vec,
    input  word_t              sp_pushed,
    input  word_t              sp_popped,
    output word_t              sp_base,
    output logic [ID_W-1:0]    vec_id,
    output logic [NUM_SRC-1:0] snap,
    output logic               pick,
    output logic               busy,
    output mem_cmd_t           cmd,
    output reg_upd_t           upd
);

    seq_state_e         state;
    word_t              pc_q;
    word_t              sr_q;
    word_t              sp_q;
    logic [ID_W-1:0]    id_q;
    logic [NUM_SRC-1:0] snap_q;

    logic take_ret;
    logic take_irq;

    assign take_ret = insn_done && reti_req;
    assign take_irq = insn_done && !reti_req && sr_cur[GIE_BIT] && (|irq_pend);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            pc_q   <= '0;
            sr_q   <= '0;
            sp_q   <= '0;
            id_q   <= '0;
            snap_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (take_ret) begin
                        sp_q  <= word_align(sp_cur);
                        state <= ST_POP_SR_RD;
                    end else if (take_irq) begin
                        pc_q   <= pc_cur;
                        sr_q   <= sr_cur;
                        sp_q   <= word_align(sp_cur);
                        snap_q <= irq_pend;
                        state  <= ST_PUSH_PC;
                    end
                end
                ST_PUSH_PC:   state <= ST_PUSH_SR;
                ST_PUSH_SR:   state <= ST_PICK;
                ST_PICK: begin
                    id_q  <= win_id;
                    state <= ST_VEC_RD;
                end
                ST_VEC_RD:    state <= ST_VEC_LD;
                ST_VEC_LD:    state <= ST_IDLE;
                ST_POP_SR_RD: state <= ST_POP_SR_LD;
                ST_POP_SR_LD: state <= ST_POP_PC_LD;
                ST_POP_PC_LD: state <= ST_IDLE;
                default:      state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd  = '{op: MEM_IDLE, addr: '0, wdata: '0};
        upd  = '0;
        pick = 1'b0;
        unique case (state)
            ST_PUSH_PC: begin
                cmd.op    = MEM_WRITE;
                cmd.addr  = a_push_pc;
                cmd.wdata = pc_q;
            end
            ST_PUSH_SR: begin
                cmd.op     = MEM_WRITE;
                cmd.addr   = a_push_sr;
                cmd.wdata  = sr_q;
                upd.sp_ld  = 1'b1;
                upd.sp_val = sp_pushed;
            end
            ST_PICK: begin
                pick       = win_found;
                upd.sr_ld  = 1'b1;
                upd.sr_val = '0;
            end
            ST_VEC_RD: begin
                cmd.op   = MEM_READ;
                cmd.addr = a_vec;
            end
            ST_VEC_LD: begin
                upd.pc_ld  = 1'b1;
                upd.pc_val = mem_rdata;
            end
            ST_POP_SR_RD: begin
                cmd.op   = MEM_READ;
                cmd.addr = a_pop_sr;
            end
            ST_POP_SR_LD: begin
                cmd.op     = MEM_READ;
                cmd.addr   = a_pop_pc;
                upd.sr_ld  = 1'b1;
                upd.sr_val = mem_rdata;
            end
            ST_POP_PC_LD: begin
                upd.pc_ld  = 1'b1;
                upd.pc_val = mem_rdata;
                upd.sp_ld  = 1'b1;
                upd.sp_val = sp_popped;
            end
            default: ;
        endcase
    end

    assign busy    = (state != ST_IDLE);
    assign sp_base = sp_q;
    assign vec_id  = id_q;
    assign snap    = snap_q;

    // R1: no boundary strobe, no start
    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !insn_done) |=> (state == ST_IDLE));

    // R1: global enable low and no return, no start
    assert_gie_gate_R1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !reti_req && !sr_cur[GIE_BIT]) |=> (state == ST_IDLE));

    // R2: second push lands one word below the first
    assert_push_adjacent_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PUSH_PC) |=> (cmd.op == MEM_WRITE && cmd.addr == $past(cmd.addr) - 16'd2));

    // R7: program counter slot is one word above the status slot
    assert_pop_adjacent_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_POP_SR_RD) |=> (cmd.op == MEM_READ && cmd.addr == $past(cmd.addr) + 16'd2));

    // R5: status word was zeroed before the vector is loaded
    assert_sr_cleared_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_VEC_LD) |-> ($past(upd.sr_ld, 2) && $past(upd.sr_val, 2) == '0));

endmodule

// File: rtl/irq_seq.sv
module irq_seq
    import irq_seq_pkg::*;
#(
    parameter int                 NUM_SRC         = 8,
    parameter logic [15:0]        VEC_TOP         = 16'hFFFE,
    parameter logic [NUM_SRC-1:0] SINGLE_SRC_MASK = 8'h7F
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               insn_done,
    input  logic               reti_req,
    input  logic [NUM_SRC-1:0] irq_pend,
    output logic [NUM_SRC-1:0] irq_clr,
    input  logic [15:0]        pc_cur,
    input  logic [15:0]        sr_cur,
    input  logic [15:0]        sp_cur,
    output logic               pc_load,
    output logic [15:0]        pc_next,
    output logic               sr_load,
    output logic [15:0]        sr_next,
    output logic               sp_load,
    output logic [15:0]        sp_next,
    output logic               mem_req,
    output logic               mem_we,
    output logic [15:0]        mem_addr,
    output logic [15:0]        mem_wdata,
    input  logic [15:0]        mem_rdata,
    output logic               busy
);

    localparam int ID_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    word_t              sp_base;
    logic [ID_W-1:0]    vec_id;
    logic [NUM_SRC-1:0] snap;
    logic               pick;
    logic               win_found;
    logic [ID_W-1:0]    win_id;
    word_t              a_push_pc, a_push_sr, a_pop_sr, a_pop_pc, a_vec;
    word_t              sp_pushed, sp_popped;
    mem_cmd_t           cmd;
    reg_upd_t           upd;

    irq_prio #(
        .NUM_SRC (NUM_SRC),
        .ID_W    (ID_W)
    ) u_prio (
        .req   (irq_pend | snap),
        .found (win_found),
        .id    (win_id)
    );

    irq_stack_agu #(
        .ID_W    (ID_W),
        .VEC_TOP (VEC_TOP)
    ) u_agu (
        .sp_base   (sp_base),
        .vec_id    (vec_id),
        .a_push_pc (a_push_pc),
        .a_push_sr (a_push_sr),
        .a_pop_sr  (a_pop_sr),
        .a_pop_pc  (a_pop_pc),
        .a_vec     (a_vec),
        .sp_pushed (sp_pushed),
        .sp_popped (sp_popped)
    );

    irq_seq_ctrl #(
        .NUM_SRC (NUM_SRC),
        .ID_W    (ID_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .insn_done (insn_done),
        .reti_req  (reti_req),
        .irq_pend  (irq_pend),
        .pc_cur    (pc_cur),
        .sr_cur    (sr_cur),
        .sp_cur    (sp_cur),
        .mem_rdata (mem_rdata),
        .win_found (win_found),
        .win_id    (win_id),
        .a_push_pc (a_push_pc),
        .a_push_sr (a_push_sr),
        .a_pop_sr  (a_pop_sr),
        .a_pop_pc  (a_pop_pc),
        .a_vec     (a_vec),
        .sp_pushed (sp_pushed),
        .sp_popped (sp_popped),
        .sp_base   (sp_base),
        .vec_id    (vec_id),
        .snap      (snap),
        .pick      (pick),
        .busy      (busy),
        .cmd       (cmd),
        .upd       (upd)
    );

    // Auto-clear only exists for single-source request lines.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_clr
        if (SINGLE_SRC_MASK[g]) begin : g_single
            assign irq_clr[g] = pick && (win_id == ID_W'(g));
        end else begin : g_multi
            assign irq_clr[g] = 1'b0;
        end
    end

    assign mem_req   = (cmd.op != MEM_IDLE);
    assign mem_we    = (cmd.op == MEM_WRITE);
    assign mem_addr  = cmd.addr;
    assign mem_wdata = cmd.wdata;
    assign pc_load   = upd.pc_ld;
    assign pc_next   = upd.pc_val;
    assign sr_load   = upd.sr_ld;
    assign sr_next   = upd.sr_val;
    assign sp_load   = upd.sp_ld;
    assign sp_next   = upd.sp_val;

    // R4: at most one flag cleared, and only inside a sequence
    assert_clr_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq_clr));
    assert_clr_in_seq_R4: assert property (@(posedge clk) disable iff (rst)
        (|irq_clr) |-> busy);

    // R9: an idle cycle makes no memory access
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy) |-> (!mem_req && !pc_load));

endmodule

// File: tb/irq_seq_test.sv
`timescale 1ns/1ps
module irq_seq_test;

    localparam int          N     = 8;
    localparam logic [15:0] VT    = 16'hFFFE;
    localparam logic [7:0]  SMASK = 8'h7F;

    logic        clk = 1'b0;
    logic        rst;
    logic        insn_done, reti_req;
    logic [7:0]  flags, irq_clr;
    logic [15:0] pc_cur, sr_cur, sp_cur;
    logic        pc_load, sr_load, sp_load;
    logic [15:0] pc_next, sr_next, sp_next;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        busy;

    always #2.5 clk = ~clk;

    irq_seq #(.NUM_SRC(N), .VEC_TOP(VT), .SINGLE_SRC_MASK(SMASK)) uut (
        .clk(clk), .rst(rst), .insn_done(insn_done), .reti_req(reti_req),
        .irq_pend(flags), .irq_clr(irq_clr),
        .pc_cur(pc_cur), .sr_cur(sr_cur), .sp_cur(sp_cur),
        .pc_load(pc_load), .pc_next(pc_next), .sr_load(sr_load), .sr_next(sr_next),
        .sp_load(sp_load), .sp_next(sp_next),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy)
    );

    logic [15:0] mem [logic [15:0]];
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    int busy_cnt, wr_cnt, rd_cnt, req_cnt;
    logic [15:0] wr_a [4];
    logic [15:0] wr_d [4];
    logic [15:0] rd_a [4];
    logic [7:0]  clr_seen;
    logic        last_busy;

    function automatic logic [15:0] vec_val(input int id);
        return 16'hC000 + 16'(id) * 16'h0102;
    endfunction

    function automatic int hi_idx(input logic [7:0] f);
        int r = -1;
        for (int i = 0; i < N; i++) if (f[i]) r = i;
        return r;
    endfunction

    function automatic logic [15:0] al(input logic [15:0] a);
        return {a[15:1], 1'b0};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic clear_log();
        busy_cnt = 0; wr_cnt = 0; rd_cnt = 0; req_cnt = 0; clr_seen = '0;
        for (int i = 0; i < 4; i++) begin wr_a[i] = '0; wr_d[i] = '0; rd_a[i] = '0; end
    endtask

    // Sample outputs mid-cycle, then apply their effects just after the edge.
    task automatic tick();
        logic s_busy, s_req, s_we, s_pl, s_sl, s_spl;
        logic [15:0] s_a, s_wd, s_pn, s_sn, s_spn;
        logic [7:0] s_clr;
        @(negedge clk);
        s_busy = busy; s_req = mem_req; s_we = mem_we; s_a = mem_addr; s_wd = mem_wdata;
        s_pl = pc_load; s_pn = pc_next; s_sl = sr_load; s_sn = sr_next;
        s_spl = sp_load; s_spn = sp_next; s_clr = irq_clr;
        @(posedge clk);
        #1;
        mem_rdata = 16'hDEAD;
        if (s_req) begin
            req_cnt++;
            if (s_we) begin
                mem[s_a] = s_wd;
                if (wr_cnt < 4) begin wr_a[wr_cnt] = s_a; wr_d[wr_cnt] = s_wd; end
                wr_cnt++;
            end else begin
                mem_rdata = mem.exists(s_a) ? mem[s_a] : 16'h0000;
                if (rd_cnt < 4) rd_a[rd_cnt] = s_a;
                rd_cnt++;
            end
        end
        if (s_pl)  pc_cur = s_pn;
        if (s_sl)  sr_cur = s_sn;
        if (s_spl) sp_cur = s_spn;
        flags    = flags & ~s_clr;
        clr_seen = clr_seen | s_clr;
        if (s_busy) busy_cnt++;
        last_busy = s_busy;
    endtask

    task automatic run_to_idle(input bit reti_noise);
        for (int k = 0; k < 12; k++) begin
            reti_req = reti_noise && (k < 3);
            tick();
            if (!last_busy) break;
        end
        reti_req = 1'b0;
    endtask

    task automatic do_entry(input logic [15:0] pc, input logic [15:0] sp,
                            input logic [15:0] sr, input logic [7:0] fl,
                            input int late, input bit reti_noise);
        logic [7:0]  all_fl, exp_fl, exp_clr;
        int          id;
        logic [15:0] a;
        pc_cur = pc; sp_cur = sp; sr_cur = sr; flags = fl;
        clear_log();
        insn_done = 1'b1; reti_req = 1'b0;
        tick();
        all_fl = fl;
        if (late >= 0) begin
            flags[late] = 1'b1;
            all_fl[late] = 1'b1;
        end
        run_to_idle(reti_noise);   // R8: insn_done held high while busy
        insn_done = 1'b0;
        id = hi_idx(all_fl);
        a = al(sp);
        exp_clr = SMASK[id] ? (8'h01 << id) : 8'h00;
        exp_fl = all_fl & ~exp_clr;
        chk(busy_cnt == 5, "R6", "entry busy cycles", busy_cnt, 5);
        chk(wr_cnt == 2 && wr_a[0] == a - 16'd2 && wr_d[0] == pc, "R2", "PC push",
            {wr_a[0], wr_d[0]}, {a - 16'd2, pc});
        chk(wr_a[1] == a - 16'd4 && wr_d[1] == sr, "R2", "SR push",
            {wr_a[1], wr_d[1]}, {a - 16'd4, sr});
        chk(sp_cur == a - 16'd4, "R2", "SP after entry", sp_cur, a - 16'd4);
        chk(sr_cur == 16'h0000, "R5", "SR cleared", sr_cur, 0);
        chk(rd_cnt == 1 && rd_a[0] == VT - 16'(2 * id), "R6", "vector address",
            rd_a[0], VT - 16'(2 * id));
        chk(pc_cur == vec_val(id), "R3", "vector of winner", pc_cur, vec_val(id));
        chk(clr_seen == exp_clr && flags == exp_fl, "R4", "flag clear",
            {clr_seen, flags}, {exp_clr, exp_fl});
    endtask

    task automatic do_return(input logic [15:0] exp_pc, input logic [15:0] exp_sr,
                             input logic [15:0] sp0);
        logic [15:0] a;
        a = al(sp0);
        clear_log();
        insn_done = 1'b1; reti_req = 1'b1;
        tick();
        insn_done = 1'b0; reti_req = 1'b0;
        run_to_idle(1'b0);
        chk(busy_cnt == 3 && wr_cnt == 0, "R7", "return cycles/writes",
            {busy_cnt[15:0], wr_cnt[15:0]}, {16'd3, 16'd0});
        chk(rd_cnt == 2 && rd_a[0] == a && rd_a[1] == a + 16'd2, "R7", "pop order",
            {rd_a[0], rd_a[1]}, {a, a + 16'd2});
        chk(sr_cur == exp_sr && pc_cur == exp_pc, "R7", "restored SR/PC",
            {sr_cur, pc_cur}, {exp_sr, exp_pc});
        chk(sp_cur == a + 16'd4, "R7", "SP after return", sp_cur, a + 16'd4);
    endtask

    task automatic idle_run(input string tag);
        clear_log();
        repeat (4) tick();
        chk(busy_cnt == 0 && req_cnt == 0, "R1", tag,
            {busy_cnt[15:0], req_cnt[15:0]}, 0);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R6: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] pc, sp, sr;
        logic [7:0]  fl;
        int          late;
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) mem[VT - 16'(2 * i)] = vec_val(i);
        rst = 1'b1; insn_done = 1'b0; reti_req = 1'b0; flags = 8'h00;
        pc_cur = 16'h1000; sr_cur = 16'h0008; sp_cur = 16'h0400; mem_rdata = 16'h0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        flags = 8'h10;
        @(negedge clk);
        chk(!busy && !mem_req && !pc_load && !sr_load && !sp_load && irq_clr == 0,
            "R9", "post-reset quiet", {busy, mem_req, pc_load, sr_load, sp_load}, 0);

        // R1: no boundary strobe
        idle_run("no entry without insn_done");
        // R1: global enable low
        sr_cur = 16'hFFF7; insn_done = 1'b1;
        idle_run("no entry with enable low");
        // R1: nothing pending
        sr_cur = 16'h0008; flags = 8'h00;
        idle_run("no entry with no request");
        insn_done = 1'b0;

        // R3: late higher request wins; R4: earlier single-source flags untouched
        do_entry(16'h2222, 16'h0500, 16'h0018, 8'h03, 5, 1'b1);
        do_return(16'h2222, 16'h0018, sp_cur);
        flags = 8'h00;
        // R4: multi-source line 7 keeps its flag
        do_entry(16'h3334, 16'h0601, 16'h00F8, 8'h81, -1, 1'b0);
        do_return(16'h3334, 16'h00F8, sp_cur);
        flags = 8'h00;
        // R6: lowest id uses the top vector slot
        do_entry(16'h4444, 16'h0700, 16'h0008, 8'h01, -1, 1'b0);
        do_return(16'h4444, 16'h0008, sp_cur);

        // R7: return takes precedence over a pending interrupt; odd SP ignored (R2/R7)
        mem[16'h0300] = 16'h0048; mem[16'h0302] = 16'hABCD;
        flags = 8'h05; sr_cur = 16'h0008; sp_cur = 16'h0301;
        do_return(16'hABCD, 16'h0048, 16'h0301);
        flags = 8'h00;

        for (int it = 0; it < 40; it++) begin
            pc = 16'($urandom);
            sr = 16'($urandom) | 16'h0008;
            sp = 16'h0200 + 16'($urandom % 32'h6000);
            fl = 8'($urandom);
            if (fl == 0) fl = 8'h40;
            late = ($urandom % 3 == 0) ? int'($urandom % N) : -1;
            do_entry(pc, sp, sr, fl, late, 1'($urandom));
            do_return(pc, sr, sp_cur);
            flags = 8'h00;
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule